// File: doc/BRIEF.md
# Spark Output Fault Monitor

This block watches the four spark driver outputs through one digital threshold bit per channel. Each bit is 1 when the channel's pin voltage is above the fault threshold. The block combines these bits with the driver state to produce one active-low fault flag. The driver state is the high-impedance request, the enable and the selected channel.

The rule that decides a fault depends on the driver state:

- **High impedance:** any pin above the threshold means an open load. A short to battery looks exactly the same, so the flag cannot tell the two apart.
- **Enable low:** any pin above the threshold means a short to battery.
- **Enable high:** the selected pin is expected to be high. A fault is flagged when the selected pin is low and no other pin is above the threshold. A battery short on any pin therefore masks a ground short.

The rule switches on the next clock edge after the driver state changes. As a result, the raw flag shows the expected false faults while the pins are still slewing.

The threshold bits come from an analog comparator, so they pass through a synchronizer before the rule sees them. A second, filtered flag is provided for software that wants settled results. It is forced to "no fault" for a parameterised number of clock cycles after any change of high-impedance request, enable or selection. This window stands for the settling interval the pins need before the fault status can be trusted. Outside the window, the filtered flag follows the raw flag.

Top module: `ign_fault_mon`

## Requirements
- R1: While reset is asserted and on the first sample after it, `fault_n_o` and `fault_filt_n_o` are both 1.
- R2: With `hiz_i`=1, `fault_n_o` is 0 if and only if any synchronized threshold bit is 1. `en_i` and `sel_i` have no effect on it.
- R3: With `hiz_i`=0 and `en_i`=0, `fault_n_o` is 0 if and only if any synchronized threshold bit is 1.
- R4: With `hiz_i`=0 and `en_i`=1, `fault_n_o` is 0 when no synchronized threshold bit is 1. In that case the selected channel (bit index `sel_i`) reads below the threshold.
- R5: With `hiz_i`=0 and `en_i`=1, `fault_n_o` is 1 whenever any synchronized threshold bit is 1, including a bit of a channel that is not selected.
- R6: A change on `above_i` reaches `fault_n_o` on the third rising clock edge. A change on `hiz_i`, `en_i` or `sel_i` takes effect on the next rising edge.
- R7: At a rising edge where the sampled {`hiz_i`, `en_i`, `sel_i`} differs from its value at the previous edge, `fault_filt_n_o` becomes 1. It stays 1 for `BLANK_CYC` edges in total, counted from that edge. A further change restarts the window. The value compared against at the first edge after reset is {1, 0, 0}.
- R8: Outside a blanking window, `fault_filt_n_o` equals `fault_n_o`. `fault_filt_n_o` is never 0 while `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| above_i | input | NCH | Per-channel threshold bit, 1 = pin above the fault threshold (asynchronous) |
| hiz_i | input | 1 | 1 = outputs held in high impedance |
| en_i | input | 1 | 1 = selected output driven high |
| sel_i | input | SELW | Index of the selected channel |
| fault_n_o | output | 1 | Raw fault flag, 0 = fault |
| fault_filt_n_o | output | 1 | Fault flag with transition blanking, 0 = fault |

## Verification
A threshold bit passes two synchronizer flops and the output register, so its effect on the raw flag is due three edges after it is driven. A change of mode or selection is due one edge later, and the filtered flag is due on that same edge. The bench drives inputs on the falling edge. Its behavioural model keeps a queue of the threshold samples taken at each rising edge and applies the rule to the sample that is two edges old. Both flags are compared with the model at every falling edge, so each result is checked in exactly the cycle it is due. A directed sequence also confirms the three-edge latency explicitly by observing the raw flag after each of the three edges.

// File: rtl/ign_fault_pkg.sv
package ign_fault_pkg;

   typedef enum logic [1:0] {
      DRV_HIZ = 2'd0,
      DRV_OFF = 2'd1,
      DRV_ON  = 2'd2
   } drv_mode_e;

   // High impedance takes priority over the enable.
   function automatic drv_mode_e drv_mode(input logic hiz, input logic en);
      if (hiz)     return DRV_HIZ;
      else if (en) return DRV_ON;
      else         return DRV_OFF;
   endfunction

endpackage

// File: rtl/ign_sync.sv
module ign_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ign_fault_rule.sv
module ign_fault_rule
   import ign_fault_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int SELW = 2
) (
   input  drv_mode_e       mode_i,
   input  logic [NCH-1:0]  above_i,
   input  logic [SELW-1:0] sel_i,
   output logic            fault_o
);

   logic [NCH-1:0] sel_hot;
   logic           any_above;
   logic           others_above;
   logic           sel_low;

   always_comb begin
      sel_hot = '0;
      for (int i = 0; i < NCH; i++) sel_hot[i] = (sel_i == SELW'(i));
   end

   assign any_above    = |above_i;
   assign others_above = |(above_i & ~sel_hot);
   assign sel_low      = ~|(above_i & sel_hot);

   always_comb begin
      unique case (mode_i)
         DRV_HIZ: fault_o = any_above;                  // open load or battery short
         DRV_OFF: fault_o = any_above;                  // battery short
         DRV_ON:  fault_o = sel_low & ~others_above;    // ground short, masked by any high pin
         default: fault_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ign_blank.sv
module ign_blank #(
   parameter bit          BLANK_EN  = 1'b1,
   parameter int          BLANK_CYC = 400,
   parameter int          KW        = 4,
   parameter logic [KW-1:0] KEY_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [KW-1:0] key_i,
   output logic          hold_o
);

   localparam int CW = $clog2(BLANK_CYC + 1);

   if (BLANK_EN) begin : g_blank
      logic [KW-1:0] key_q;
      logic [CW-1:0] cnt_q;
      logic          chg;

      assign chg    = (key_i != key_q);
      assign hold_o = chg | (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            key_q <= KEY_RST;
            cnt_q <= '0;
         end else begin
            key_q <= key_i;
            if (chg)               cnt_q <= CW'(BLANK_CYC - 1);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
      end
   end else begin : g_pass
      logic unused_inputs;
      assign unused_inputs = ^{key_i, clk, rst_n};
      assign hold_o        = 1'b0;
   end

endmodule

// File: rtl/ign_fault_mon.sv
module ign_fault_mon
   import ign_fault_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit BLANK_EN    = 1'b1,
   parameter int BLANK_CYC   = 400,
   parameter int SELW        = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  above_i,
   input  logic            hiz_i,
   input  logic            en_i,
   input  logic [SELW-1:0] sel_i,
   output logic            fault_n_o,
   output logic            fault_filt_n_o
);

   localparam int KW = SELW + 2;
   localparam logic [KW-1:0] KEY_RST = {1'b1, 1'b0, {SELW{1'b0}}};

   if (NCH < 2)              begin : g_bad_nch   $error("NCH must be at least 2");            end
   if (SELW != $clog2(NCH))  begin : g_bad_selw  $error("SELW must equal clog2(NCH)");       end
   if (SYNC_STAGES < 1)      begin : g_bad_sync  $error("SYNC_STAGES must be at least 1");   end
   if (BLANK_EN && BLANK_CYC < 1) begin : g_bad_blank $error("BLANK_CYC must be at least 1"); end

   logic [NCH-1:0] above_s;
   drv_mode_e      mode_c;
   logic           fault_c;
   logic           hold_c;

   ign_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (above_i),
      .q_o   (above_s)
   );

   assign mode_c = drv_mode(hiz_i, en_i);

   ign_fault_rule #(.NCH(NCH), .SELW(SELW)) u_rule (
      .mode_i  (mode_c),
      .above_i (above_s),
      .sel_i   (sel_i),
      .fault_o (fault_c)
   );

   ign_blank #(.BLANK_EN(BLANK_EN), .BLANK_CYC(BLANK_CYC), .KW(KW), .KEY_RST(KEY_RST)) u_blank (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_i  ({hiz_i, en_i, sel_i}),
      .hold_o (hold_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_n_o      <= 1'b1;
         fault_filt_n_o <= 1'b1;
      end else begin
         fault_n_o      <= ~fault_c;
         fault_filt_n_o <= hold_c ? 1'b1 : ~fault_c;
      end
   end

endmodule

// File: rtl/ign_fault_mon_chk.sv
module ign_fault_mon_chk #(
   parameter int NCH         = 4,
   parameter int SELW        = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit BLANK_EN    = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NCH-1:0]  above_i,
   input logic            hiz_i,
   input logic            en_i,
   input logic [SELW-1:0] sel_i,
   input logic            fault_n_o,
   input logic            fault_filt_n_o
);

   logic [1:0] age_q;
   logic       ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   assign ok = (age_q == 2'd3) && (SYNC_STAGES == 2);

   // R2: high impedance, any pin high gives a fault
   p_hiz_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ok && hiz_i && (|$past(above_i, 2)) |=> !fault_n_o);

   // R3: disabled, battery short reported, clean pins report none
   p_off_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !hiz_i && !en_i && (|$past(above_i, 2)) |=> !fault_n_o);
   p_off_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !hiz_i && !en_i && ($past(above_i, 2) == '0) |=> fault_n_o);

   // R4: enabled, no pin high means the selected output is grounded
   p_on_ground_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !hiz_i && en_i && ($past(above_i, 2) == '0) |=> !fault_n_o);

   // R5: enabled, any high pin masks the ground check
   p_on_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !hiz_i && en_i && (|$past(above_i, 2)) |=> fault_n_o);

   // R7: a mode or selection change forces the filtered flag high
   p_blank_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      BLANK_EN && ok && ({hiz_i, en_i, sel_i} != $past({hiz_i, en_i, sel_i})) |=> fault_filt_n_o);

   // R8: the filtered flag never reports a fault the raw flag does not
   p_filt_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_filt_n_o |-> !fault_n_o);

endmodule

bind ign_fault_mon ign_fault_mon_chk #(
   .NCH(NCH), .SELW(SELW), .SYNC_STAGES(SYNC_STAGES), .BLANK_EN(BLANK_EN)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .above_i        (above_i),
   .hiz_i          (hiz_i),
   .en_i           (en_i),
   .sel_i          (sel_i),
   .fault_n_o      (fault_n_o),
   .fault_filt_n_o (fault_filt_n_o)
);

// File: tb/ign_fault_mon_tb_top.sv
module ign_fault_mon_tb_top;

   localparam int NCH   = 4;
   localparam int SELW  = 2;
   localparam int BLANK = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  above = '0;
   logic            hiz = 1'b1;
   logic            en = 1'b0;
   logic [SELW-1:0] sel = '0;
   logic            fault_n;
   logic            filt_n;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ign_fault_mon #(.NCH(NCH), .SYNC_STAGES(2), .BLANK_EN(1'b1), .BLANK_CYC(BLANK)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .above_i        (above),
      .hiz_i          (hiz),
      .en_i           (en),
      .sel_i          (sel),
      .fault_n_o      (fault_n),
      .fault_filt_n_o (filt_n)
   );

   // Behavioural reference model
   int       hist[$];
   int       m_seen;
   int       m_prev;
   int       m_cnt;
   bit       m_hold;
   bit       exp_f = 1'b1;
   bit       exp_filt = 1'b1;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         hist.delete();
         m_prev = 8;          // {hiz=1, en=0, sel=0}
         m_cnt  = 0;
         m_hold = 1'b0;
         exp_f  = 1'b1;
         exp_filt = 1'b1;
         m_seen = 0;
      end else begin
         int key;
         bit flt;
         m_seen = (hist.size() == 2) ? hist.pop_front() : 0;
         hist.push_back(int'(above));
         if (hiz)           flt = (m_seen != 0);
         else if (!en)      flt = (m_seen != 0);
         else               flt = (m_seen == 0);
         key = {28'd0, hiz, en, sel};
         if (key != m_prev) begin
            m_hold = 1'b1;
            m_cnt  = BLANK - 1;
         end else if (m_cnt > 0) begin
            m_hold = 1'b1;
            m_cnt--;
         end else begin
            m_hold = 1'b0;
         end
         m_prev   = key;
         exp_f    = !flt;
         exp_filt = m_hold ? 1'b1 : !flt;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   task automatic step();
      string ftag;
      @(posedge clk);
      @(negedge clk);
      if (hiz)                ftag = "R2";
      else if (!en)           ftag = "R3";
      else if (m_seen == 0)   ftag = "R4";
      else                    ftag = "R5";
      check(ftag, fault_n, exp_f, "raw fault");
      check(m_hold ? "R7" : "R8", filt_n, exp_filt, "filtered fault");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1", fault_n, 1'b1, "raw in reset");
      check("R1", filt_n, 1'b1, "filtered in reset");
      rst_n = 1'b1;
      step();
      check("R1", fault_n, 1'b1, "raw after reset");
      check("R1", filt_n, 1'b1, "filtered after reset");

      // R6: latency of a threshold bit, disabled mode
      hiz = 1'b0; en = 1'b0; sel = 2'd1;
      repeat (BLANK + 4) step();
      above = 4'b0100;
      step(); check("R6", fault_n, 1'b1, "after edge 1");
      step(); check("R6", fault_n, 1'b1, "after edge 2");
      step(); check("R6", fault_n, 1'b0, "after edge 3");
      // R6: mode change takes effect on next edge
      en = 1'b1;
      step(); check("R6", fault_n, 1'b1, "mode switch next edge");
      above = '0;
      repeat (4) step();

      // Exhaustive sweep of mode, selection and threshold bits
      for (int m = 0; m < 3; m++) begin
         for (int s = 0; s < NCH; s++) begin
            for (int a = 0; a < (1 << NCH); a++) begin
               hiz = (m == 0); en = (m == 2); sel = SELW'(s);
               above = NCH'(a);
               repeat (3) step();
            end
         end
      end
      // hiz with enable high: R2 says en has no effect
      hiz = 1'b1; en = 1'b1;
      for (int a = 0; a < (1 << NCH); a++) begin
         above = NCH'(a);
         repeat (3) step();
      end

      // R7: rapid selection changes retrigger the window
      hiz = 1'b0; en = 1'b1; above = '0;
      repeat (BLANK + 3) step();
      for (int k = 0; k < 8; k++) begin
         sel = SELW'(k);
         repeat (2) step();
      end
      repeat (BLANK + 3) step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule